// File: doc/BRIEF.md
# Recursive Systematic Convolutional Encoder

This block is one constituent encoder of a turbo code. Each accepted data bit is passed through unchanged as the systematic output. A parity bit is formed from a shift register whose input is the data bit combined with a feedback sum of selected register taps. The tap polynomials and the register length are chosen at run time. The short mode uses three delays (8 states) and the long mode uses four delays (16 states). The block can also be built with other register lengths.

A block begins with a start strobe, which clears the register. Data bits follow under a valid strobe. A terminate request then starts a tail phase. For as many cycles as the register has delays, the encoder feeds its own feedback sum back in, so the recursive node sees zero and the register empties to the all-zero state. The tail systematic and parity bits go out on the normal output, flagged as termination bits. Interleaving, puncturing and combining the two encoders are handled outside this block.

Top module: `rsc_encoder`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `out_valid`, `term_active`, `out_sys` and `out_par` are 0.
- R2: Polynomial encoding: for memory length m (short mode, `cfg_long`=0, m=MEM_MAX-1), bit m of a polynomial field is the coefficient at the input end and bit m-k is the tap on delay k. In short mode each data bit gives node = d xor (fb lead coefficient and xor of fb taps times state). The new state is the node shifted in at delay 1. Parity = (ff lead and node) xor (xor of ff taps times state). Defaults are feedback 1011 and feed-forward 1101.
- R3: In long mode (`cfg_long`=1, m=MEM_MAX) the same rules apply with 5-bit polynomials. The typical pair is feedback 10011 and feed-forward 11011.
- R4: A data bit accepted in cycle t appears in cycle t+1 with `out_valid`=1, `term_active`=0 and `out_sys` equal to the input bit.
- R5: `blk_start` clears the register and aborts any running termination. A data bit presented in the same cycle is encoded from the zero state. `blk_start` alone produces no output.
- R6: A `term_req` accepted outside termination produces no output in that cycle. It is followed by exactly m outputs with `term_active`=1, whose systematic bit is the feedback sum and whose parity is computed with a zero node.
- R7: While termination runs, `in_valid` and `term_req` are ignored. No extra output appears after the m tail bits.
- R8: After termination the register is all zero: data sent afterwards without `blk_start` is encoded from the zero state.
- R9: Mode and polynomials are captured at `blk_start`. Changes on the configuration pins during a block have no effect.
- R10: In any cycle without output, `out_valid`, `term_active`, `out_sys` and `out_par` are 0.
- R11: When `term_req` and `in_valid` are both high outside termination, the request wins and the data bit is dropped.
- R12: A feedback lead coefficient of 0 makes the code non-recursive. Its tail bits are then all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_long | input | 1 | 1 selects the long register (MEM_MAX delays), 0 the short one |
| cfg_fb | input | MEM_MAX+1 | Feedback polynomial, input-end coefficient at bit m |
| cfg_ff | input | MEM_MAX+1 | Feed-forward polynomial, input-end coefficient at bit m |
| blk_start | input | 1 | Start of block: clear register, capture configuration |
| in_valid | input | 1 | Data bit strobe |
| in_bit | input | 1 | Data bit |
| term_req | input | 1 | Request trellis termination |
| out_valid | output | 1 | Registered output strobe |
| out_sys | output | 1 | Systematic bit (data or tail) |
| out_par | output | 1 | Parity bit |
| term_active | output | 1 | Output belongs to the termination tail |

## Verification
A wrong register bit stays hidden until a tapped delay reaches it. It then shows as a wrong parity within at most m outputs, and as wrong tail systematic bits during termination. Leftover state after the tail shows up at the first parity bits of the next block sent without a start strobe. Every data pattern of a short block is swept in both modes and with several polynomials, including a non-recursive one. This exposes a wrong or misplaced tap within one block.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
  localparam int unsigned MEM_MAX_DEF = 4;

  typedef enum logic {
    MODE_SHORT = 1'b0,
    MODE_LONG  = 1'b1
  } rsc_mode_e;
endpackage

// File: rtl/rsc_tap_map.sv
// Turns a right-aligned polynomial field into taps indexed by delay.
// taps[0] is the input-end coefficient, taps[k] the tap on delay k.
module rsc_tap_map #(
  parameter int unsigned MEM_MAX = 4
) (
  input  rsc_pkg::rsc_mode_e mode,
  input  logic [MEM_MAX:0]   poly,
  output logic [MEM_MAX:0]   taps
);
  for (genvar k = 0; k <= MEM_MAX; k++) begin : g_tap
    if (k == MEM_MAX) begin : g_top
      // deepest delay exists only in the long mode
      assign taps[k] = (mode == rsc_pkg::MODE_LONG) ? poly[0] : 1'b0;
    end else begin : g_mid
      assign taps[k] = (mode == rsc_pkg::MODE_LONG) ? poly[MEM_MAX-k]
                                                    : poly[MEM_MAX-1-k];
    end
  end
endmodule

// File: rtl/rsc_term_ctrl.sv
// Sequences data steps and the tail phase.
module rsc_term_ctrl #(
  parameter int unsigned MEM_MAX = 4,
  localparam int unsigned CNT_W  = $clog2(MEM_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             blk_start,
  input  logic             in_valid,
  input  logic             term_req,
  input  logic [CNT_W-1:0] tail_len,
  output logic             do_data,
  output logic             do_tail,
  output logic             tail_run
);
  logic [CNT_W-1:0] left_q;
  logic             start_tail;

  always_comb begin
    do_data    = in_valid & (blk_start | (~tail_run & ~term_req));
    do_tail    = tail_run & ~blk_start;
    start_tail = term_req & ~tail_run & ~blk_start;
  end

  always_ff @(posedge clk) begin
    if (rst || blk_start) begin
      tail_run <= 1'b0;
      left_q   <= '0;
    end else if (start_tail) begin
      tail_run <= 1'b1;
      left_q   <= tail_len;
    end else if (do_tail) begin
      left_q   <= left_q - 1'b1;
      tail_run <= (left_q > CNT_W'(1));
    end
  end
endmodule

// File: rtl/rsc_core.sv
// Shift register, feedback node and parity with registered outputs.
module rsc_core #(
  parameter int unsigned MEM_MAX = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               do_data,
  input  logic               do_tail,
  input  logic               in_bit,
  input  rsc_pkg::rsc_mode_e mode,
  input  logic [MEM_MAX:0]   fb_taps,
  input  logic [MEM_MAX:0]   ff_taps,
  output logic               out_valid,
  output logic               out_sys,
  output logic               out_par,
  output logic               term_active
);
  logic [MEM_MAX:1] st_q, st_eff, st_nxt, keep_mask;
  logic             fb_sum, feed, node, par;

  for (genvar k = 1; k <= MEM_MAX; k++) begin : g_keep
    if (k == MEM_MAX) begin : g_last
      assign keep_mask[k] = (mode == rsc_pkg::MODE_LONG);
    end else begin : g_other
      assign keep_mask[k] = 1'b1;
    end
  end

  always_comb begin
    st_eff = clear ? '0 : st_q;
    fb_sum = fb_taps[0] & (^(fb_taps[MEM_MAX:1] & st_eff));
    feed   = do_tail ? fb_sum : in_bit;
    node   = feed ^ fb_sum;
    par    = (ff_taps[0] & node) ^ (^(ff_taps[MEM_MAX:1] & st_eff));
    st_nxt = {st_eff[MEM_MAX-1:1], node} & keep_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= '0;
      out_valid   <= 1'b0;
      out_sys     <= 1'b0;
      out_par     <= 1'b0;
      term_active <= 1'b0;
    end else begin
      if (do_data || do_tail) begin
        st_q <= st_nxt;
      end else if (clear) begin
        st_q <= '0;
      end
      out_valid   <= do_data | do_tail;
      out_sys     <= (do_data | do_tail) & feed;
      out_par     <= (do_data | do_tail) & par;
      term_active <= do_tail;
    end
  end
endmodule

// File: rtl/rsc_encoder.sv
module rsc_encoder #(
  parameter int unsigned     MEM_MAX  = rsc_pkg::MEM_MAX_DEF,
  parameter logic            DEF_LONG = 1'b0,
  parameter logic [MEM_MAX:0] DEF_FB  = (MEM_MAX+1)'(4'b1011),
  parameter logic [MEM_MAX:0] DEF_FF  = (MEM_MAX+1)'(4'b1101),
  localparam int unsigned    CNT_W    = $clog2(MEM_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_long,
  input  logic [MEM_MAX:0] cfg_fb,
  input  logic [MEM_MAX:0] cfg_ff,
  input  logic             blk_start,
  input  logic             in_valid,
  input  logic             in_bit,
  input  logic             term_req,
  output logic             out_valid,
  output logic             out_sys,
  output logic             out_par,
  output logic             term_active
);
  rsc_pkg::rsc_mode_e mode_q, mode_eff;
  logic [MEM_MAX:0]   fb_q, ff_q, fb_eff, ff_eff, fb_taps, ff_taps;
  logic [CNT_W-1:0]   tail_len;
  logic               do_data, do_tail, tail_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= rsc_pkg::rsc_mode_e'(DEF_LONG);
      fb_q   <= DEF_FB;
      ff_q   <= DEF_FF;
    end else if (blk_start) begin
      mode_q <= rsc_pkg::rsc_mode_e'(cfg_long);
      fb_q   <= cfg_fb;
      ff_q   <= cfg_ff;
    end
  end

  always_comb begin
    mode_eff = blk_start ? rsc_pkg::rsc_mode_e'(cfg_long) : mode_q;
    fb_eff   = blk_start ? cfg_fb : fb_q;
    ff_eff   = blk_start ? cfg_ff : ff_q;
    tail_len = (mode_eff == rsc_pkg::MODE_LONG) ? CNT_W'(MEM_MAX)
                                                : CNT_W'(MEM_MAX - 1);
  end

  rsc_tap_map #(.MEM_MAX(MEM_MAX)) u_fb_map (
    .mode(mode_eff), .poly(fb_eff), .taps(fb_taps)
  );

  rsc_tap_map #(.MEM_MAX(MEM_MAX)) u_ff_map (
    .mode(mode_eff), .poly(ff_eff), .taps(ff_taps)
  );

  rsc_term_ctrl #(.MEM_MAX(MEM_MAX)) u_ctrl (
    .clk(clk), .rst(rst), .blk_start(blk_start), .in_valid(in_valid),
    .term_req(term_req), .tail_len(tail_len), .do_data(do_data),
    .do_tail(do_tail), .tail_run(tail_run)
  );

  rsc_core #(.MEM_MAX(MEM_MAX)) u_core (
    .clk(clk), .rst(rst), .clear(blk_start), .do_data(do_data),
    .do_tail(do_tail), .in_bit(in_bit), .mode(mode_eff),
    .fb_taps(fb_taps), .ff_taps(ff_taps), .out_valid(out_valid),
    .out_sys(out_sys), .out_par(out_par), .term_active(term_active)
  );
endmodule

// File: rtl/rsc_encoder_chk.sv
module rsc_encoder_chk #(
  parameter int unsigned MEM_MAX = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             blk_start,
  input logic             in_valid,
  input logic             in_bit,
  input logic             term_req,
  input logic             out_valid,
  input logic             out_sys,
  input logic             out_par,
  input logic             term_active,
  input logic             tail_run,
  input logic [MEM_MAX:1] st_q,
  input logic             mode_long
);
  int unsigned run_len;

  always_ff @(posedge clk) begin
    if (rst || !term_active) run_len <= 0;
    else                     run_len <= run_len + 1;
  end

  // R4: accepted data bit echoes one cycle later as a non-tail output
  p_sys_echo_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !term_req && !tail_run) |=>
      (out_valid && !term_active && out_sys == $past(in_bit)));

  // R5: a start strobe ends any tail phase
  p_start_clears_r5: assert property (@(posedge clk) disable iff (rst)
    blk_start |=> !term_active);

  // R6: tail run never exceeds the register length
  p_tail_len_r6: assert property (@(posedge clk) disable iff (rst)
    term_active |-> (run_len < (mode_long ? MEM_MAX : MEM_MAX - 1)));

  // R7: every running tail cycle yields a tail output, whatever the inputs
  p_tail_step_r7: assert property (@(posedge clk) disable iff (rst)
    (tail_run && !blk_start) |=> (out_valid && term_active));

  // R8: a completed tail leaves the register empty
  p_zero_after_tail_r8: assert property (@(posedge clk) disable iff (rst)
    ($fell(tail_run) && !$past(blk_start)) |-> (st_q == '0));

  // R10: idle outputs are quiet
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_sys && !out_par && !term_active));
endmodule

bind rsc_encoder rsc_encoder_chk #(.MEM_MAX(MEM_MAX)) u_chk (
  .clk(clk), .rst(rst), .blk_start(blk_start), .in_valid(in_valid),
  .in_bit(in_bit), .term_req(term_req), .out_valid(out_valid),
  .out_sys(out_sys), .out_par(out_par), .term_active(term_active),
  .tail_run(u_ctrl.tail_run), .st_q(u_core.st_q),
  .mode_long(mode_q == rsc_pkg::MODE_LONG)
);

// File: tb/rsc_encoder_tb_top.sv
module rsc_encoder_tb_top;
  localparam int unsigned MEM_MAX = 4;

  logic clk = 1'b0;
  logic rst, cfg_long, blk_start, in_valid, in_bit, term_req;
  logic [MEM_MAX:0] cfg_fb, cfg_ff;
  logic out_valid, out_sys, out_par, term_active;

  int n_checks = 0;
  int n_errors = 0;

  // reference model state
  logic             m_long;
  logic [MEM_MAX:0] m_fb, m_ff;
  logic [MEM_MAX:1] ms;

  always #5 clk = ~clk;

  rsc_encoder #(.MEM_MAX(MEM_MAX)) dut_i (
    .clk(clk), .rst(rst), .cfg_long(cfg_long), .cfg_fb(cfg_fb),
    .cfg_ff(cfg_ff), .blk_start(blk_start), .in_valid(in_valid),
    .in_bit(in_bit), .term_req(term_req), .out_valid(out_valid),
    .out_sys(out_sys), .out_par(out_par), .term_active(term_active)
  );

  initial begin
    #(200000 * 10);
    n_checks++;
    n_errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  // expected = {valid, term, sys, par}
  task automatic chk(input string tag, input logic [3:0] exp);
    logic [3:0] act;
    act = {out_valid, term_active, out_sys, out_par};
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  function automatic int mlen();
    return m_long ? MEM_MAX : MEM_MAX - 1;
  endfunction

  function automatic logic tap(input logic [MEM_MAX:0] p, input int k);
    int m;
    m = mlen();
    if (k > m) return 1'b0;
    return p[m-k];
  endfunction

  task automatic model_start();
    m_long = cfg_long;
    m_fb   = cfg_fb;
    m_ff   = cfg_ff;
    ms     = '0;
  endtask

  task automatic model_step(input logic is_tail, input logic d,
                            output logic sys, output logic par);
    logic fbs, a;
    logic [MEM_MAX:1] nx;
    fbs = 1'b0;
    par = 1'b0;
    for (int k = 1; k <= mlen(); k++) begin
      fbs ^= tap(m_fb, k) & ms[k];
      par ^= tap(m_ff, k) & ms[k];
    end
    fbs = fbs & tap(m_fb, 0);
    sys = is_tail ? fbs : d;
    a   = sys ^ fbs;
    par = par ^ (tap(m_ff, 0) & a);
    nx  = '0;
    nx[1] = a;
    for (int k = 2; k <= mlen(); k++) nx[k] = ms[k-1];
    ms = nx;
  endtask

  task automatic send_bit(input logic start, input logic d, input string tag);
    logic s, p;
    in_valid  = 1'b1;
    in_bit    = d;
    blk_start = start;
    if (start) model_start();
    model_step(1'b0, d, s, p);
    cyc();
    in_valid  = 1'b0;
    blk_start = 1'b0;
    chk(tag, {2'b10, s, p});
  endtask

  task automatic run_term(input logic noise);
    logic s, p;
    term_req = 1'b1;
    in_valid = noise;
    in_bit   = 1'b1;
    cyc();
    chk(noise ? "R11 data dropped on request" : "R6 request cycle", 4'b0000);
    for (int i = 0; i < mlen(); i++) begin
      term_req = noise;
      in_valid = noise;
      model_step(1'b1, 1'b0, s, p);
      cyc();
      chk(tap(m_fb, 0) ? "R6 tail bit" : "R12 feed-forward tail", {2'b11, s, p});
    end
    term_req = 1'b0;
    in_valid = 1'b0;
    cyc();
    chk("R7 no extra output after tail", 4'b0000);
  endtask

  function automatic logic [MEM_MAX:0] pick_fb(input logic lng, input int i);
    if (lng) return (i == 0) ? 5'b10011 : (i == 1) ? 5'b11001 : 5'b00101;
    return (i == 0) ? 5'b01011 : (i == 1) ? 5'b01101 : 5'b00011;
  endfunction

  function automatic logic [MEM_MAX:0] pick_ff(input logic lng, input int i);
    if (lng) return (i == 0) ? 5'b11011 : (i == 1) ? 5'b10111 : 5'b11101;
    return (i == 0) ? 5'b01101 : (i == 1) ? 5'b01111 : 5'b01011;
  endfunction

  initial begin
    logic s, p;
    rst = 1'b1; cfg_long = 1'b0; cfg_fb = 5'b01011; cfg_ff = 5'b01101;
    blk_start = 1'b0; in_valid = 1'b0; in_bit = 1'b0; term_req = 1'b0;
    @(negedge clk);
    cyc();
    chk("R1 during reset", 4'b0000);
    cyc();
    rst = 1'b0;
    cyc();
    chk("R1 after reset", 4'b0000);
    chk("R10 idle", 4'b0000);

    // sweep: both modes, three polynomial pairs, all 6-bit patterns
    for (int md = 0; md < 2; md++) begin
      for (int pi = 0; pi < 3; pi++) begin
        for (int pat = 0; pat < 64; pat++) begin
          cfg_long = md[0];
          cfg_fb   = pick_fb(md[0], pi);
          cfg_ff   = pick_ff(md[0], pi);
          send_bit(1'b1, pat[0], md[0] ? "R3 long mode" : "R2 short mode");
          if (pat[1]) begin
            cfg_long = ~cfg_long;
            cfg_fb   = ~cfg_fb;
            cfg_ff   = ~cfg_ff;
          end
          for (int i = 1; i < 6; i++)
            send_bit(1'b0, pat[i], pat[1] ? "R9 config held" : "R4 data echo");
          run_term(pat[2]);
          send_bit(1'b0, pat[3], "R8 resume from zero");
          send_bit(1'b0, pat[4], "R8 resume from zero");
        end
      end
    end

    // abort of a running tail by a start strobe with data
    cfg_long = 1'b1; cfg_fb = 5'b10011; cfg_ff = 5'b11011;
    send_bit(1'b1, 1'b1, "R3 long mode");
    send_bit(1'b0, 1'b1, "R3 long mode");
    term_req = 1'b1;
    cyc();
    chk("R6 request cycle", 4'b0000);
    term_req = 1'b0;
    model_step(1'b1, 1'b0, s, p);
    cyc();
    chk("R6 tail bit", {2'b11, s, p});
    cfg_long = 1'b0; cfg_fb = 5'b01011; cfg_ff = 5'b01101;
    send_bit(1'b1, 1'b1, "R5 start aborts tail");
    send_bit(1'b0, 1'b0, "R5 after abort");

    // start strobe without data clears the register
    send_bit(1'b0, 1'b1, "R2 short mode");
    blk_start = 1'b1;
    model_start();
    cyc();
    blk_start = 1'b0;
    chk("R5 start alone quiet", 4'b0000);
    send_bit(1'b0, 1'b1, "R5 encoded from zero");
    send_bit(1'b0, 1'b1, "R5 encoded from zero");
    run_term(1'b0);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule